// File: doc/BRIEF.md
# Split-Space User Address Translator

This block maps the virtual addresses of a user process onto physical memory, with separate translation for the data space and the code space. A request carries a privilege flag, a space selector, a direction flag and a 16-bit virtual address. In the same cycle, the block returns either a physical address or a violation flag together with the virtual address that caused it. Privileged requests are not translated: their address passes through unchanged to the physical kernel segments.

The data space holds 64 KB and counts in bytes. The code space holds 128 KB and counts in 16-bit words, because every instruction is two bytes long and aligned. Both spaces therefore use a 16-bit virtual address. The data space is cut into sixteen 4 KB pages. The code space is cut into thirty-two pages of 2K words.

A flat table of page entries is held in flops. Privileged software moves a base register to select one process's group of entries. It writes and reads single entries at base plus an offset, where the offset is the sum of two registers already formed outside the block. A process's data pages occupy slots base+0 to base+15. Its code pages occupy slots base+16 to base+47. All slot arithmetic wraps around the table depth.

Top module: `mmu_split_space`

## Requirements
- R1: After reset the base register is 0 and every table entry reads as 0, so every user request raises a violation.
- R2: A valid request with `req_kernel`=1 yields `pa` equal to `req_vaddr` zero-extended and `viol`=0, whatever the table holds.
- R3: A valid user data request (`req_code`=0) looks up slot base+`req_vaddr[15:12]`. On success `pa` = {ppn, `req_vaddr[11:0]`}.
- R4: A valid user code request (`req_code`=1) looks up slot base+16+`req_vaddr[15:11]`. On success `pa` = {1'b0, ppn, `req_vaddr[10:0]`}.
- R5: A user request whose entry has the valid bit (bit 9) clear raises `viol`. `viol_vaddr` then equals `req_vaddr` and `pa` is 0.
- R6: A user write whose entry is valid but has the writable bit (bit 8) clear raises `viol`. A read of the same page succeeds. The ppn sits in bits 7:0.
- R7: `pte_rdata` shows, in the same cycle, the entry at slot base+`pte_off`.
- R8: A `pte_we` write takes effect at the clock edge. A translation or readback in the same cycle still sees the old entry.
- R9: A `ptb_we` load takes effect at the clock edge. A translation in the same cycle still uses the old base.
- R10: With `req_valid`=0, `viol`=0 and `pa`=0. Whenever `viol`=0, `viol_vaddr` is 0.
- R11: Slot sums wrap modulo the 64-entry table depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_kernel | input | 1 | Privileged request, bypasses translation |
| req_code | input | 1 | 1 = code space, 0 = data space |
| req_write | input | 1 | 1 = write access |
| req_vaddr | input | 16 | Virtual address (bytes for data, words for code) |
| pa | output | 20 | Physical address |
| viol | output | 1 | Translation or permission violation |
| viol_vaddr | output | 16 | Faulting virtual address, 0 when no violation |
| ptb_we | input | 1 | Load the table base register |
| ptb_wdata | input | 6 | New base slot |
| pte_we | input | 1 | Write one table entry |
| pte_off | input | 6 | Entry offset from base, for write and readback |
| pte_wdata | input | 10 | Entry to write {valid, writable, ppn} |
| pte_rdata | output | 10 | Entry at base+pte_off |

## Verification
A table-entry write, or a base load, can fall in the same cycle as a user translation that reads the very slot being changed. The bench provokes this on purpose: it writes an entry and requests its page in one cycle, then loads a new base while it translates. It expects the old mapping in that cycle and the new one in the next. Random cycles mix writes, base loads and requests freely, and the reference model judges every one of them.

// File: rtl/mmu_ss_pkg.sv
package mmu_ss_pkg;
  localparam int VA_W      = 16;
  localparam int DOFF_W    = 12;
  localparam int COFF_W    = 11;
  localparam int PPN_W     = 8;
  localparam int TBL_AW    = 6;
  localparam int DIDX_W    = VA_W - DOFF_W;
  localparam int CIDX_W    = VA_W - COFF_W;
  localparam int CODE_SLOT = 1 << DIDX_W;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int PA_W      = PPN_W + DOFF_W;

  typedef struct packed {
    logic             valid;
    logic             writable;
    logic [PPN_W-1:0] ppn;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);

  function automatic logic [TBL_AW-1:0] slot_of(input logic [TBL_AW-1:0] base,
                                                input logic code,
                                                input logic [VA_W-1:0] vaddr);
    logic [TBL_AW-1:0] page;
    if (code) page = TBL_AW'(CODE_SLOT) + TBL_AW'(vaddr[VA_W-1:COFF_W]);
    else      page = TBL_AW'(vaddr[VA_W-1:DOFF_W]);
    return base + page;
  endfunction

  function automatic logic [PA_W-1:0] pa_of(input logic [PPN_W-1:0] ppn,
                                            input logic code,
                                            input logic [VA_W-1:0] vaddr);
    if (code) return {{(PA_W-PPN_W-COFF_W){1'b0}}, ppn, vaddr[COFF_W-1:0]};
    return {ppn, vaddr[DOFF_W-1:0]};
  endfunction
endpackage

// File: rtl/mmu_ptb_reg.sv
module mmu_ptb_reg
  import mmu_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptb_we,
  input  logic [TBL_AW-1:0] ptb_wdata,
  input  logic [TBL_AW-1:0] kport_off,
  output logic [TBL_AW-1:0] ptb_q,
  output logic [TBL_AW-1:0] kport_slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptb_q <= '0;
    else if (ptb_we) ptb_q <= ptb_wdata;
  end

  assign kport_slot = ptb_q + kport_off;
endmodule

// File: rtl/mmu_pte_store.sv
module mmu_pte_store
  import mmu_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TBL_AW-1:0] waddr,
  input  pte_t              wdata,
  input  logic [TBL_AW-1:0] raddr_a,
  output pte_t              rdata_a,
  input  logic [TBL_AW-1:0] raddr_b,
  output pte_t              rdata_b
);
  pte_t ent_q [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             ent_q[g] <= '0;
      else if (we && waddr == TBL_AW'(g))     ent_q[g] <= wdata;
    end
  end

  assign rdata_a = ent_q[raddr_a];
  assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/mmu_walk.sv
module mmu_walk
  import mmu_ss_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_kernel,
  input  logic              req_code,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [TBL_AW-1:0] ptb_q,
  output logic [TBL_AW-1:0] lookup_slot,
  input  pte_t              lookup_pte,
  output logic              user_access,
  output logic              miss,
  output logic              perm_fail,
  output logic [PA_W-1:0]   pa,
  output logic              viol,
  output logic [VA_W-1:0]   viol_vaddr
);
  always_comb begin
    lookup_slot = slot_of(ptb_q, req_code, req_vaddr);
    user_access = req_valid && !req_kernel;
    miss        = user_access && !lookup_pte.valid;
    perm_fail   = user_access && lookup_pte.valid && req_write && !lookup_pte.writable;
    viol        = miss || perm_fail;
    viol_vaddr  = viol ? req_vaddr : '0;
    if (!req_valid || viol) pa = '0;
    else if (req_kernel)    pa = {{(PA_W-VA_W){1'b0}}, req_vaddr};
    else                    pa = pa_of(lookup_pte.ppn, req_code, req_vaddr);
  end
endmodule

// File: rtl/mmu_split_space.sv
module mmu_split_space
  import mmu_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kernel,
  input  logic              req_code,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic [PA_W-1:0]   pa,
  output logic              viol,
  output logic [VA_W-1:0]   viol_vaddr,
  input  logic              ptb_we,
  input  logic [TBL_AW-1:0] ptb_wdata,
  input  logic              pte_we,
  input  logic [TBL_AW-1:0] pte_off,
  input  logic [PTE_W-1:0]  pte_wdata,
  output logic [PTE_W-1:0]  pte_rdata
);
  logic [TBL_AW-1:0] ptb_q;
  logic [TBL_AW-1:0] kport_slot;
  logic [TBL_AW-1:0] lookup_slot;
  pte_t              lookup_pte;
  pte_t              kport_pte;
  logic              user_access;
  logic              miss;
  logic              perm_fail;

  mmu_ptb_reg u_ptb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptb_we     (ptb_we),
    .ptb_wdata  (ptb_wdata),
    .kport_off  (pte_off),
    .ptb_q      (ptb_q),
    .kport_slot (kport_slot)
  );

  mmu_pte_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (pte_we),
    .waddr   (kport_slot),
    .wdata   (pte_t'(pte_wdata)),
    .raddr_a (lookup_slot),
    .rdata_a (lookup_pte),
    .raddr_b (kport_slot),
    .rdata_b (kport_pte)
  );

  mmu_walk u_walk (
    .req_valid   (req_valid),
    .req_kernel  (req_kernel),
    .req_code    (req_code),
    .req_write   (req_write),
    .req_vaddr   (req_vaddr),
    .ptb_q       (ptb_q),
    .lookup_slot (lookup_slot),
    .lookup_pte  (lookup_pte),
    .user_access (user_access),
    .miss        (miss),
    .perm_fail   (perm_fail),
    .pa          (pa),
    .viol        (viol),
    .viol_vaddr  (viol_vaddr)
  );

  assign pte_rdata = kport_pte;
endmodule

// File: rtl/mmu_split_space_chk.sv
module mmu_split_space_chk
  import mmu_ss_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_kernel,
  input logic              req_code,
  input logic              req_write,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [PA_W-1:0]   pa,
  input logic              viol,
  input logic [VA_W-1:0]   viol_vaddr,
  input logic              ptb_we,
  input logic [TBL_AW-1:0] ptb_wdata,
  input logic              pte_we,
  input logic [TBL_AW-1:0] pte_off,
  input logic [PTE_W-1:0]  pte_wdata,
  input logic [PTE_W-1:0]  pte_rdata,
  input logic [TBL_AW-1:0] ptb_q,
  input pte_t              lookup_pte
);
  p_kernel_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kernel) |-> (!viol && pa == PA_W'(req_vaddr)));

  p_viol_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_vaddr == req_vaddr && pa == '0));

  p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel && req_write && lookup_pte.valid && !lookup_pte.writable) |-> viol);

  p_user_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel && !req_code && lookup_pte.valid && !req_write)
      |-> (!viol && pa[DOFF_W-1:0] == req_vaddr[DOFF_W-1:0]));

  p_pte_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_we && !ptb_we) |=> (pte_rdata == $past(pte_wdata) || pte_off != $past(pte_off)));

  p_ptb_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptb_we |=> (ptb_q == $past(ptb_wdata)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!viol && pa == '0 && viol_vaddr == '0));
endmodule

bind mmu_split_space mmu_split_space_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kernel (req_kernel),
  .req_code   (req_code),
  .req_write  (req_write),
  .req_vaddr  (req_vaddr),
  .pa         (pa),
  .viol       (viol),
  .viol_vaddr (viol_vaddr),
  .ptb_we     (ptb_we),
  .ptb_wdata  (ptb_wdata),
  .pte_we     (pte_we),
  .pte_off    (pte_off),
  .pte_wdata  (pte_wdata),
  .pte_rdata  (pte_rdata),
  .ptb_q      (ptb_q),
  .lookup_pte (lookup_pte)
);

// File: tb/mmu_split_space_tb.sv
module mmu_split_space_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_kernel = 0, req_code = 0, req_write = 0;
  logic [15:0] req_vaddr = '0;
  logic [19:0] pa;
  logic        viol;
  logic [15:0] viol_vaddr;
  logic        ptb_we = 0;
  logic [5:0]  ptb_wdata = '0;
  logic        pte_we = 0;
  logic [5:0]  pte_off = '0;
  logic [9:0]  pte_wdata = '0;
  logic [9:0]  pte_rdata;

  int total = 0;
  int bad = 0;
  int tbl [64];
  int base = 0;

  always #10 clk = ~clk;

  mmu_split_space dut_i (.*);

  task automatic idle();
    req_valid = 0; req_kernel = 0; req_code = 0; req_write = 0; req_vaddr = '0;
    ptb_we = 0; pte_we = 0;
  endtask

  task automatic step(input string tag);
    int e_pa, e_viol, e_va, e_rd, idx, ent, ppn;
    #5;
    e_pa = 0; e_viol = 0; e_va = 0;
    if (req_valid) begin
      if (req_kernel) e_pa = req_vaddr;
      else begin
        if (req_code) idx = (base + 16 + (req_vaddr / 2048)) % 64;
        else          idx = (base + (req_vaddr / 4096)) % 64;
        ent = tbl[idx];
        ppn = ent % 256;
        if ((ent / 512) % 2 == 0 || (req_write && (ent / 256) % 2 == 0)) begin
          e_viol = 1; e_va = req_vaddr;
        end else if (req_code) e_pa = ppn * 2048 + req_vaddr % 2048;
        else                   e_pa = ppn * 4096 + req_vaddr % 4096;
      end
    end
    e_rd = tbl[(base + pte_off) % 64];
    total++;
    if (pa !== 20'(e_pa) || viol !== 1'(e_viol) || viol_vaddr !== 16'(e_va)
        || pte_rdata !== 10'(e_rd)) begin
      bad++;
      $display("FAIL %s: pa=%h viol=%b va=%h rd=%h expected pa=%h viol=%0d va=%h rd=%h",
               tag, pa, viol, viol_vaddr, pte_rdata, e_pa, e_viol, e_va, e_rd);
    end
    if (pte_we) tbl[(base + pte_off) % 64] = pte_wdata;
    if (ptb_we) base = ptb_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic kwrite(input int off, input int val, input string tag);
    pte_we = 1; pte_off = 6'(off); pte_wdata = 10'(val);
    step(tag);
  endtask

  task automatic acc(input bit k, input bit c, input bit w, input int va, input string tag);
    req_valid = 1; req_kernel = k; req_code = c; req_write = w; req_vaddr = 16'(va);
    step(tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    pte_off = 6'd7; step("R1");
    acc(0, 0, 0, 16'h1234, "R1");
    acc(0, 1, 0, 16'hFFFF, "R1");
    // R2: kernel bypass
    acc(1, 0, 1, 16'hBEEF, "R2");
    acc(1, 1, 0, 16'h0001, "R2");
    // fill process at base 0
    for (int i = 0; i < 16; i++)
      kwrite(i, (i == 3) ? 0 : (512 + ((i % 2 == 0) ? 256 : 0) + 8'h30 + i), "R7");
    for (int j = 0; j < 32; j++)
      kwrite(16 + j, (j == 5) ? 256 : (512 + 256 + 8'h80 + j), "R7");
    acc(1, 0, 0, 16'h3004, "R2");
    // R3, R4 hits
    acc(0, 0, 0, 16'h2ABC, "R3");
    acc(0, 0, 1, 16'h4001, "R3");
    acc(0, 1, 0, 16'h0FFF, "R4");
    acc(0, 1, 1, 16'hF7FF, "R4");
    // R5 invalid
    acc(0, 0, 0, 16'h3004, "R5");
    acc(0, 1, 0, 16'h2802, "R5");
    // R6 read-only page 1
    acc(0, 0, 1, 16'h1010, "R6");
    acc(0, 0, 0, 16'h1010, "R6");
    // R7 readback
    pte_off = 6'd47; step("R7");
    // R8: write and translate same slot same cycle
    req_valid = 1; req_vaddr = 16'h3000; pte_we = 1; pte_off = 6'd3;
    pte_wdata = 10'h3AA; step("R8");
    acc(0, 0, 0, 16'h3000, "R8");
    // R9: base load alongside translation, then R11 wrap
    req_valid = 1; req_vaddr = 16'h2000; ptb_we = 1; ptb_wdata = 6'd40;
    step("R9");
    acc(0, 0, 0, 16'h2000, "R9");
    kwrite(47, 512 + 8'hC7, "R11");
    acc(0, 1, 0, 16'hF900, "R11");
    pte_off = 6'd47; step("R11");
    // R10 idle
    req_vaddr = 16'h1234; req_write = 1; step("R10");
    // random mix
    for (int n = 0; n < 600; n++) begin
      req_valid  = ($urandom % 4) != 0;
      req_kernel = ($urandom % 5) == 0;
      req_code   = $urandom % 2;
      req_write  = $urandom % 2;
      req_vaddr  = 16'($urandom);
      pte_we     = ($urandom % 3) == 0;
      pte_off    = 6'($urandom);
      pte_wdata  = 10'($urandom);
      ptb_we     = ($urandom % 16) == 0;
      ptb_wdata  = 6'($urandom);
      step("R8");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule